// File: doc/BRIEF.md
# Multi-Level Sequential Trigger Unit

This block watches a bus of probed signals on the sampling clock and raises a trigger once a programmed series of conditions has been seen in order. Every level holds one condition per probed bit. A bit condition is a level test (low, high), an edge test (rising, falling, either) or don't-care. Edges are judged against the sample taken one clock earlier. A level matches when all of its enabled bit conditions hold in the same cycle.

The levels are walked one after another. Only the current level is compared. A match moves the sequencer to the next level, and the trigger fires when the last active level matches. The final step can also be made to wait for an active-low external trigger input. On firing, the block gives a one-cycle event strobe meant for a capture buffer, and a one-cycle active-low trigger output four sampling clocks later.

Conditions, the probe mask and the control word are loaded through a small register write port. Software starts each run with an arm pulse.

Top module: `seq_trig`

## Requirements
- R1: After reset, trig_out_n is 1, trig_event, triggered and armed are 0, and cur_level is 0. The configuration resets to every condition don't-care, every mask bit 1, one active level, and external trigger disabled.
- R2: The condition for probe bit i sits in bits [3i+2:3i] of a level word. The codes are 000 don't-care, 001 low, 010 high, 011 rising (now 1, previous sample 0), 100 falling, and 101 either edge. Codes 110 and 111 behave as don't-care.
- R3: A level matches only when every enabled bit condition is true in the same sample.
- R4: Only the level at cur_level is compared. A match advances cur_level by one, and a mismatch leaves it unchanged (no restart). The trigger fires when the last active level matches.
- R5: A probe bit whose mask bit is 0 is ignored by every level.
- R6: Control bits [LVL_W-1:0] give the number of active levels. A value of 0 acts as 1, and a value above MAX_LEVELS acts as MAX_LEVELS. cur_level never reaches MAX_LEVELS.
- R7: Control bit LVL_W enables the external trigger. When it is enabled, the last level counts only if ext_trig_n is 0 in the same sample. Earlier levels do not depend on ext_trig_n.
- R8: trig_event is high for exactly the one cycle after the clock edge at which the final match is sampled. trig_out_n is low for exactly one cycle, starting OUT_DELAY (default 4) edges after trig_event rises.
- R9: On firing, triggered is set and armed is cleared. Triggered stays set, cur_level stays put and no further event occurs until arm. Arm sets armed, clears triggered and returns cur_level to 0.
- R10: Configuration writes made while armed are ignored.
- R11: Write addresses 0 to MAX_LEVELS-1 select level words, address MAX_LEVELS selects the probe mask (bit i = 1 enables probe bit i), and address MAX_LEVELS+1 selects the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe | input | PROBE_W | Probed signal bus |
| ext_trig_n | input | 1 | External trigger, active low |
| arm | input | 1 | Starts a new run at level 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 3*PROBE_W | Configuration write data |
| trig_event | output | 1 | One-cycle strobe for a capture buffer |
| trig_out_n | output | 1 | Delayed trigger pulse, active low |
| triggered | output | 1 | Sticky fired flag |
| armed | output | 1 | Run in progress |
| cur_level | output | LVL_W | Index of the level being compared |

## Verification
The hardest state to reach from the ports is an edge condition judged against exactly the sample before the one being compared. That previous sample has to be set up before arming takes effect. The bench reaches it by resetting, writing a single-level condition, and holding the first probe value during the arm cycle so that it becomes the previous sample. It then presents the second value on the very next edge.

It repeats this for every code and every previous/current pair. It also sweeps all 256 probe values against a two-bit AND, and walks out-of-order, partial, locked-configuration and ten-level sequences.

// File: rtl/seq_trig_pkg.sv
`timescale 1ns/1ps
package seq_trig_pkg;

   localparam int COND_W = 3;

   typedef enum logic [COND_W-1:0] {
      CND_ANY  = 3'd0,
      CND_LOW  = 3'd1,
      CND_HIGH = 3'd2,
      CND_RISE = 3'd3,
      CND_FALL = 3'd4,
      CND_EDGE = 3'd5
   } cond_e;

   // Evaluate one bit condition against the present and previous sample.
   function automatic logic cond_eval(input logic [COND_W-1:0] c,
                                      input logic now_b,
                                      input logic old_b);
      logic r;
      case (c)
         CND_LOW:  r = !now_b;
         CND_HIGH: r = now_b;
         CND_RISE: r = now_b && !old_b;
         CND_FALL: r = !now_b && old_b;
         CND_EDGE: r = now_b ^ old_b;
         default:  r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/seq_trig_cfg.sv
`timescale 1ns/1ps
module seq_trig_cfg #(
   parameter int PROBE_W    = 8,
   parameter int MAX_LEVELS = 10,
   parameter int LVL_W      = 4,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 24
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 lock,
   input  logic                                 we,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [MAX_LEVELS-1:0][DATA_W-1:0]    lvl_cond,
   output logic [PROBE_W-1:0]                   mask,
   output logic [LVL_W-1:0]                     nlev_eff,
   output logic                                 ext_en
);

   localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MAX_LEVELS);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(MAX_LEVELS + 1);

   logic             wr_ok;
   logic [LVL_W-1:0] nlev_raw;

   assign wr_ok = we && !lock;

   generate
      for (genvar g = 0; g < MAX_LEVELS; g++) begin : g_lvl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvl_cond[g] <= '0;
            else if (wr_ok && addr == ADDR_W'(g))
               lvl_cond[g] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '1;
         nlev_raw <= LVL_W'(1);
         ext_en   <= 1'b0;
      end else if (wr_ok) begin
         if (addr == MASK_ADDR)
            mask <= wdata[PROBE_W-1:0];
         if (addr == CTRL_ADDR) begin
            nlev_raw <= wdata[LVL_W-1:0];
            ext_en   <= wdata[LVL_W];
         end
      end
   end

   always_comb begin
      if (nlev_raw == '0)
         nlev_eff = LVL_W'(1);
      else if (nlev_raw > LVL_W'(MAX_LEVELS))
         nlev_eff = LVL_W'(MAX_LEVELS);
      else
         nlev_eff = nlev_raw;
   end

endmodule

// File: rtl/seq_trig_match.sv
`timescale 1ns/1ps
module seq_trig_match #(
   parameter int PROBE_W = 8,
   localparam int CW     = seq_trig_pkg::COND_W
) (
   input  logic [CW*PROBE_W-1:0] cond,
   input  logic [PROBE_W-1:0]    mask,
   input  logic [PROBE_W-1:0]    cur,
   input  logic [PROBE_W-1:0]    prv,
   output logic                  hit
);

   logic [PROBE_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < PROBE_W; i++) begin : g_bit
         assign bit_ok[i] = !mask[i] ||
                            seq_trig_pkg::cond_eval(cond[CW*i +: CW], cur[i], prv[i]);
      end
   endgenerate

   assign hit = &bit_ok;

endmodule

// File: rtl/seq_trig_seq.sv
`timescale 1ns/1ps
module seq_trig_seq #(
   parameter int MAX_LEVELS = 10,
   parameter int LVL_W      = 4,
   parameter int OUT_DELAY  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             hit,
   input  logic             ext_n,
   input  logic             ext_en,
   input  logic [LVL_W-1:0] nlev,
   output logic             armed,
   output logic             triggered,
   output logic [LVL_W-1:0] level,
   output logic             evt,
   output logic             out_n
);

   logic                 last, ext_ok, fire;
   logic [OUT_DELAY-1:0] dly;

   assign last   = (level == nlev - LVL_W'(1));
   assign ext_ok = !ext_en || !ext_n;
   assign fire   = armed && !arm && hit && last && ext_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         triggered <= 1'b0;
         level     <= '0;
         evt       <= 1'b0;
      end else begin
         evt <= fire;
         if (arm) begin
            armed     <= 1'b1;
            triggered <= 1'b0;
            level     <= '0;
         end else if (fire) begin
            armed     <= 1'b0;
            triggered <= 1'b1;
         end else if (armed && hit && !last) begin
            level <= level + LVL_W'(1);
         end
      end
   end

   generate
      if (OUT_DELAY == 1) begin : g_dly_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly <= '0;
            else        dly <= evt;
         end
      end else begin : g_dly_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly <= '0;
            else        dly <= {dly[OUT_DELAY-2:0], evt};
         end
      end
   endgenerate

   assign out_n = !dly[OUT_DELAY-1];

endmodule

// File: rtl/seq_trig.sv
`timescale 1ns/1ps
module seq_trig #(
   parameter int  PROBE_W    = 8,
   parameter int  MAX_LEVELS = 10,
   parameter int  OUT_DELAY  = 4,
   localparam int LVL_W      = $clog2(MAX_LEVELS + 1),
   localparam int ADDR_W     = $clog2(MAX_LEVELS + 2),
   localparam int DATA_W     = seq_trig_pkg::COND_W * PROBE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PROBE_W-1:0] probe,
   input  logic              ext_trig_n,
   input  logic              arm,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              trig_event,
   output logic              trig_out_n,
   output logic              triggered,
   output logic              armed,
   output logic [LVL_W-1:0]  cur_level
);

   generate
      if (PROBE_W < 1 || MAX_LEVELS < 1 || OUT_DELAY < 1 || DATA_W < LVL_W + 1) begin : g_bad_cfg
         $error("seq_trig: illegal parameter set");
      end
   endgenerate

   logic [PROBE_W-1:0]                prv;
   logic [MAX_LEVELS-1:0][DATA_W-1:0] lvl_cond;
   logic [PROBE_W-1:0]                mask;
   logic [LVL_W-1:0]                  nlev_eff;
   logic                              ext_en;
   logic [DATA_W-1:0]                 cond_sel;
   logic                              hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= '0;
      else        prv <= probe;
   end

   seq_trig_cfg #(
      .PROBE_W(PROBE_W), .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .lock(armed), .we(cfg_we),
      .addr(cfg_addr), .wdata(cfg_wdata), .lvl_cond(lvl_cond),
      .mask(mask), .nlev_eff(nlev_eff), .ext_en(ext_en)
   );

   always_comb begin
      cond_sel = '0;
      for (int i = 0; i < MAX_LEVELS; i++)
         if (cur_level == LVL_W'(i)) cond_sel = lvl_cond[i];
   end

   seq_trig_match #(.PROBE_W(PROBE_W)) u_match (
      .cond(cond_sel), .mask(mask), .cur(probe), .prv(prv), .hit(hit)
   );

   seq_trig_seq #(
      .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W), .OUT_DELAY(OUT_DELAY)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .ext_n(ext_trig_n),
      .ext_en(ext_en), .nlev(nlev_eff), .armed(armed), .triggered(triggered),
      .level(cur_level), .evt(trig_event), .out_n(trig_out_n)
   );

endmodule

// File: rtl/seq_trig_chk.sv
`timescale 1ns/1ps
module seq_trig_chk #(
   parameter int MAX_LEVELS = 10,
   parameter int LVL_W      = 4,
   parameter int OUT_DELAY  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             trig_event,
   input logic             trig_out_n,
   input logic             triggered,
   input logic             armed,
   input logic [LVL_W-1:0] cur_level
);

   logic [2:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_event |=> !trig_event);                                          // R8
   AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_out_n |=> trig_out_n);                                          // R8
   AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trig_event |-> (triggered && !armed));                                // R9
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> triggered);                                   // R9
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (cur_level == $past(cur_level) ||
                cur_level == $past(cur_level) + LVL_W'(1)));                // R4
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_level < LVL_W'(MAX_LEVELS));                                      // R6

   generate
      if (OUT_DELAY == 4) begin : g_dly4
         AST_OUT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 3'd5) |-> (trig_out_n == !$past(trig_event, 4))); // R8
      end
   endgenerate

endmodule

bind seq_trig seq_trig_chk #(
   .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W), .OUT_DELAY(OUT_DELAY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .trig_event(trig_event),
   .trig_out_n(trig_out_n), .triggered(triggered), .armed(armed),
   .cur_level(cur_level)
);

// File: tb/seq_trig_tb.sv
`timescale 1ns/1ps
module seq_trig_tb;
   localparam int PW = 8, ML = 10, LW = 4, AW = 4, DW = 24;
   localparam logic [AW-1:0] A_MASK = AW'(ML), A_CTRL = AW'(ML + 1);

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [PW-1:0] probe = '0;
   logic          ext_trig_n = 1'b1, arm = 1'b0, cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          trig_event, trig_out_n, triggered, armed;
   logic [LW-1:0] cur_level;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   seq_trig u_dut (
      .clk(clk), .rst_n(rst_n), .probe(probe), .ext_trig_n(ext_trig_n),
      .arm(arm), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .trig_event(trig_event), .trig_out_n(trig_out_n), .triggered(triggered),
      .armed(armed), .cur_level(cur_level)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; arm = 1'b0; cfg_we = 1'b0; probe = '0; ext_trig_n = 1'b1;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic do_arm();
      arm = 1'b1;
      tick();
      arm = 1'b0;
   endtask

   task automatic drive(input logic [PW-1:0] p);
      probe = p;
      tick();
   endtask

   // Exact-value level word: bit set -> high (010), bit clear -> low (001).
   function automatic logic [DW-1:0] exact(input logic [PW-1:0] v);
      logic [DW-1:0] w = '0;
      for (int i = 0; i < PW; i++) w[3*i +: 3] = v[i] ? 3'b010 : 3'b001;
      return w;
   endfunction

   function automatic bit expect_bit(input int code, input bit c, input bit p);
      case (code)
         1: return !c;
         2: return c;
         3: return c && !p;
         4: return !c && p;
         5: return c ^ p;
         default: return 1'b1;
      endcase
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(trig_out_n == 1'b1, "R1 trig_out_n", int'(trig_out_n), 1);
      chk(trig_event == 1'b0, "R1 trig_event", int'(trig_event), 0);
      chk(triggered == 1'b0, "R1 triggered", int'(triggered), 0);
      chk(armed == 1'b0, "R1 armed", int'(armed), 0);
      chk(cur_level == '0, "R1 cur_level", int'(cur_level), 0);

      // R11 R4 R8: 3-level opcode sequence 01, 02, 03
      wr(AW'(0), exact(8'h01));
      wr(AW'(1), exact(8'h02));
      wr(AW'(2), exact(8'h03));
      wr(A_CTRL, DW'(3));
      do_arm();
      chk(armed == 1'b1, "R9 armed after arm", int'(armed), 1);
      drive(8'h01);
      chk(cur_level == 4'd1, "R4 advance to 1", int'(cur_level), 1);
      chk(trig_event == 1'b0, "R4 no early fire", int'(trig_event), 0);
      drive(8'h02);
      chk(cur_level == 4'd2, "R4 advance to 2", int'(cur_level), 2);
      drive(8'h03);
      chk(trig_event == 1'b1, "R8 trig_event", int'(trig_event), 1);
      chk(triggered == 1'b1 && armed == 1'b0, "R9 flags on fire",
          int'({triggered, armed}), 2);
      probe = '0;
      for (int k = 1; k <= 6; k++) begin
         tick();
         chk(trig_out_n == (k == 4 ? 1'b0 : 1'b1), "R8 trig_out_n delay",
             int'(trig_out_n), (k == 4) ? 0 : 1);
         chk(trig_event == 1'b0, "R8 single event", int'(trig_event), 0);
      end

      // R9 sticky: matches after firing do nothing
      drive(8'h01); drive(8'h02); drive(8'h03);
      chk(trig_event == 1'b0, "R9 no refire", int'(trig_event), 0);
      chk(triggered == 1'b1, "R9 sticky", int'(triggered), 1);
      chk(cur_level == 4'd2, "R9 level held", int'(cur_level), 2);

      // R4 out-of-order and partial sequences
      do_arm();
      chk(triggered == 1'b0 && cur_level == '0, "R9 arm clears",
          int'(cur_level), 0);
      drive(8'h02); drive(8'h03);
      chk(cur_level == 4'd0, "R4 out of order stays 0", int'(cur_level), 0);
      drive(8'h01); drive(8'h03); drive(8'h01);
      chk(cur_level == 4'd1, "R4 no restart on miss", int'(cur_level), 1);
      drive(8'h02); drive(8'h00); drive(8'h01);
      chk(cur_level == 4'd2 && triggered == 1'b0, "R4 partial no trigger",
          int'(cur_level), 2);
      drive(8'h03);
      chk(trig_event == 1'b1, "R4 completes", int'(trig_event), 1);

      // R10 writes ignored while armed
      do_arm();
      wr(AW'(0), '0);
      drive(8'h55);
      chk(cur_level == 4'd0, "R10 locked write ignored", int'(cur_level), 0);
      drive(8'h01); drive(8'h02); drive(8'h03);
      chk(trig_event == 1'b1, "R10 old config fires", int'(trig_event), 1);

      // R5 mask bit 7 off
      wr(A_MASK, DW'(8'h7F));
      do_arm();
      drive(8'h81); drive(8'h82); drive(8'h83);
      chk(trig_event == 1'b1, "R5 masked bit ignored", int'(trig_event), 1);

      // R7 external trigger on final level only
      do_reset();
      wr(AW'(0), exact(8'h01));
      wr(AW'(1), exact(8'h02));
      wr(A_CTRL, DW'(5'h12));
      do_arm();
      drive(8'h01);
      chk(cur_level == 4'd1, "R7 non-final ignores ext", int'(cur_level), 1);
      drive(8'h02);
      chk(trig_event == 1'b0, "R7 final waits for ext", int'(trig_event), 0);
      ext_trig_n = 1'b0;
      drive(8'h02);
      chk(trig_event == 1'b1, "R7 final with ext", int'(trig_event), 1);
      ext_trig_n = 1'b1;

      // R6 zero levels acts as one
      do_reset();
      wr(AW'(0), exact(8'hA5));
      wr(A_CTRL, DW'(0));
      do_arm();
      drive(8'hA5);
      chk(trig_event == 1'b1, "R6 count 0 acts as 1", int'(trig_event), 1);

      // R6 count 15 clamps to ten levels
      do_reset();
      for (int i = 0; i < ML; i++) wr(AW'(i), exact(PW'(i + 1)));
      wr(A_CTRL, DW'(15));
      do_arm();
      for (int i = 0; i < ML; i++) begin
         drive(PW'(i + 1));
         if (i < ML - 1)
            chk(cur_level == LW'(i + 1) && !trig_event, "R6 ten-level walk",
                int'(cur_level), i + 1);
         else
            chk(trig_event == 1'b1 && cur_level == LW'(ML - 1), "R6 fires at tenth",
                int'(cur_level), ML - 1);
      end

      // R2 exhaustive single-bit code sweep against previous sample
      for (int code = 0; code < 8; code++)
         for (int p = 0; p < 2; p++)
            for (int c = 0; c < 2; c++) begin
               do_reset();
               wr(AW'(0), DW'(code));
               probe = PW'(p);
               do_arm();
               drive(PW'(c));
               chk(trig_event == expect_bit(code, c[0], p[0]), "R2 code sweep",
                   int'(trig_event), int'(expect_bit(code, c[0], p[0])));
            end

      // R3 AND of bit0 high and bit3 low over all probe values
      for (int v = 0; v < 256; v++) begin
         do_reset();
         wr(AW'(0), DW'(12'b001_000_000_010));
         do_arm();
         drive(PW'(v));
         chk(trig_event == (v[0] && !v[3]), "R3 and of bits",
             int'(trig_event), int'(v[0] && !v[3]));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule